// File: doc/BRIEF.md
# Command Doorbell Mailbox

This block hands command words from a host bus master to a coprocessor and returns that coprocessor's result. The host posts a 32-bit word into a command slot through a small register-mapped port. The word can be a pointer to a command structure or an immediate command. The coprocessor pulls the word off a valid/ready stream. When it finishes, it presents a 32-bit result and a one-cycle acknowledge pulse. The pulse sets a sticky flag that the host can read and later clear.

The command slot is also the busy indicator. While a command waits for the coprocessor, the slot reads back the nonzero posted word. It reads zero once the word has been taken. A host therefore polls the slot until it reads zero, clears the flag, posts a command, polls the flag, clears the flag again, and then reads the result register.

On the command stream, `cmd_valid` is high exactly while the slot holds a nonzero word. The coprocessor applies back-pressure by holding `cmd_ready` low. While it does so, the word on `cmd_data` stays frozen and no new post can overwrite it. A transfer happens on the rising clock edge on which both `cmd_valid` and `cmd_ready` are high. The acknowledge side is a plain pulse with no back-pressure.

Top module: `cmd_mailbox`

## Requirements
- R1: After reset the command, result and flag registers all read zero, and `cmd_valid` is low.
- R2: A host write of a nonzero word to offset 0x0 while the slot reads zero loads that word. From the next cycle, offset 0x0 reads the word, `cmd_valid` is high and `cmd_data` carries the word.
- R3: A host write to offset 0x0 while the slot holds a pending word leaves the pending word unchanged.
- R4: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid` stays high and `cmd_data` stays unchanged.
- R5: After an edge on which `cmd_valid` and `cmd_ready` are both high, offset 0x0 reads zero and `cmd_valid` is low.
- R6: A one-cycle `cop_ack` sets the flag, so offset 0x8 reads 0x1. On the same edge, `cop_status` is captured into the result register at offset 0x4.
- R7: A host write of zero to offset 0x8 clears the flag. A host write of a nonzero word to offset 0x8 leaves the flag unchanged.
- R8: When a host clear of the flag and `cop_ack` fall in the same cycle, the flag ends up set.
- R9: The result register changes only on `cop_ack`. Host writes to offset 0x4 have no effect on it.
- R10: A read of any offset other than 0x0, 0x4 and 0x8 returns zero.
- R11: A host write of zero to offset 0x0 while the slot is empty posts nothing: the slot stays zero and `cmd_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | ADDR_W | Host register byte offset |
| host_we | input | 1 | Host write strobe, one word per cycle |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational from `host_addr` |
| cmd_valid | output | 1 | Command slot holds a pending word |
| cmd_ready | input | 1 | Coprocessor takes the pending word |
| cmd_data | output | DATA_W | Pending command word |
| cop_ack | input | 1 | One-cycle acknowledge from the coprocessor |
| cop_status | input | DATA_W | Result word, captured with `cop_ack` |

## Verification
Commands are posted against an idle slot, a pending slot and a slot held under back-pressure for several cycles. This separates a write that loads from a write that must be dropped, and shows whether the stream word drifts while it waits. Zero and nonzero writes go to the flag on their own, and a clear is also driven on the same edge as an acknowledge, which exposes a wrong clear encoding or a wrong priority. Two acknowledges with different results, separated by host writes to the result offset, show that the result register updates only on the pulse. Unmapped offsets are read both with the registers empty and with all of them loaded, so a decoder that leaks a register shows up.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned OFS_CMD  = 'h0;
  localparam int unsigned OFS_STAT = 'h4;
  localparam int unsigned OFS_ACK  = 'h8;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_ACK  = 2'd2,
    SEL_NONE = 2'd3
  } mbx_sel_e;
endpackage

// File: rtl/mbx_cmd_slot.sv
module mbx_cmd_slot #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] slot_q,
  output logic          pending
);
  logic [DW-1:0] slot_d;

  assign pending = |slot_q;

  always_comb begin
    slot_d = slot_q;
    if (pending) begin
      if (take) slot_d = '0;
    end else if (wr_en) begin
      slot_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  // R3
  post_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !take && wr_en) |=> $stable(slot_q));

  // R4
  hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !take) |=> (pending && $stable(slot_q)));

  // R5
  empty_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && take) |=> !pending);
endmodule

// File: rtl/mbx_ack_stat.sv
module mbx_ack_stat #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flag_wr,
  input  logic [DW-1:0] flag_wdata,
  input  logic          ack,
  input  logic [DW-1:0] status_in,
  output logic          flag_q,
  output logic [DW-1:0] status_q
);
  logic clr_req;

  assign clr_req = flag_wr && (flag_wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q   <= 1'b0;
      status_q <= '0;
    end else begin
      if (ack) begin
        flag_q   <= 1'b1;
        status_q <= status_in;
      end else if (clr_req) begin
        flag_q <= 1'b0;
      end
    end
  end

  // R8
  ack_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> flag_q);

  // R6
  status_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> (status_q == $past(status_in)));

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack |=> $stable(status_q));

  // R7
  nonzero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack && flag_wr && flag_wdata != '0) |=> $stable(flag_q));
endmodule

// File: rtl/mbx_rd_mux.sv
module mbx_rd_mux #(
  parameter int unsigned DW = 32
) (
  input  mbx_pkg::mbx_sel_e sel,
  input  logic [DW-1:0]     slot_q,
  input  logic [DW-1:0]     status_q,
  input  logic              flag_q,
  output logic [DW-1:0]     rdata
);
  import mbx_pkg::*;

  always_comb begin
    unique case (sel)
      SEL_CMD:  rdata = slot_q;
      SEL_STAT: rdata = status_q;
      SEL_ACK:  rdata = {{(DW-1){1'b0}}, flag_q};
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmd_mailbox.sv
module cmd_mailbox #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_we,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  input  logic              cop_ack,
  input  logic [DATA_W-1:0] cop_status
);
  import mbx_pkg::*;

  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_ACK  = ADDR_W'(OFS_ACK);

  mbx_sel_e          sel;
  logic [DATA_W-1:0] slot_q;
  logic [DATA_W-1:0] status_q;
  logic              flag_q;

  always_comb begin
    if      (host_addr == A_CMD)  sel = SEL_CMD;
    else if (host_addr == A_STAT) sel = SEL_STAT;
    else if (host_addr == A_ACK)  sel = SEL_ACK;
    else                          sel = SEL_NONE;
  end

  mbx_cmd_slot #(.DW(DATA_W)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (host_we && sel == SEL_CMD),
    .wr_data (host_wdata),
    .take    (cmd_ready),
    .slot_q  (slot_q),
    .pending (cmd_valid)
  );

  assign cmd_data = slot_q;

  mbx_ack_stat #(.DW(DATA_W)) u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_wr    (host_we && sel == SEL_ACK),
    .flag_wdata (host_wdata),
    .ack        (cop_ack),
    .status_in  (cop_status),
    .flag_q     (flag_q),
    .status_q   (status_q)
  );

  mbx_rd_mux #(.DW(DATA_W)) u_rd (
    .sel      (sel),
    .slot_q   (slot_q),
    .status_q (status_q),
    .flag_q   (flag_q),
    .rdata    (host_rdata)
  );

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr != A_CMD && host_addr != A_STAT && host_addr != A_ACK) |-> (host_rdata == '0));

  // R2
  post_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_valid && host_we && host_addr == A_CMD && host_wdata != '0)
      |=> (cmd_valid && cmd_data == $past(host_wdata)));
endmodule

// File: tb/sim_cmd_mailbox.sv
`timescale 1ns/1ps
module sim_cmd_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  host_addr = '0;
  logic        host_we = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cmd_valid;
  logic        cmd_ready = 1'b0;
  logic [31:0] cmd_data;
  logic        cop_ack = 1'b0;
  logic [31:0] cop_status = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  cmd_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_data(cmd_data), .cop_ack(cop_ack),
    .cop_status(cop_status)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  // one-cycle host write; returns at the following falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    host_addr = a; host_we = 1'b1; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0; host_wdata = '0;
  endtask

  task automatic ack_pulse(input logic [31:0] s);
    cop_ack = 1'b1; cop_status = s;
    @(negedge clk);
    cop_ack = 1'b0; cop_status = '0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'h0, d); chk("R1 cmd", d, 32'h0);
    rd(4'h4, d); chk("R1 status", d, 32'h0);
    rd(4'h8, d); chk("R1 flag", d, 32'h0);
    chk("R1 valid", {31'b0, cmd_valid}, 32'h0);
  endtask

  task automatic t_post_and_take();
    logic [31:0] d;
    wr(4'h0, 32'hA5A5_0001);
    rd(4'h0, d); chk("R2 readback", d, 32'hA5A5_0001);
    chk("R2 valid", {31'b0, cmd_valid}, 32'h1);
    chk("R2 data", cmd_data, 32'hA5A5_0001);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R4 valid held", {31'b0, cmd_valid}, 32'h1);
      chk("R4 data held", cmd_data, 32'hA5A5_0001);
    end
    wr(4'h0, 32'h0000_7777);
    rd(4'h0, d); chk("R3 busy write dropped", d, 32'hA5A5_0001);
    chk("R3 stream word", cmd_data, 32'hA5A5_0001);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    rd(4'h0, d); chk("R5 slot empty", d, 32'h0);
    chk("R5 valid low", {31'b0, cmd_valid}, 32'h0);
    wr(4'h0, 32'h0000_0042);
    rd(4'h0, d); chk("R2 repost after take", d, 32'h0000_0042);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    chk("R5 second take", {31'b0, cmd_valid}, 32'h0);
  endtask

  task automatic t_zero_post();
    logic [31:0] d;
    wr(4'h0, 32'h0);
    rd(4'h0, d); chk("R11 zero post slot", d, 32'h0);
    chk("R11 zero post valid", {31'b0, cmd_valid}, 32'h0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    ack_pulse(32'h0000_1234);
    rd(4'h8, d); chk("R6 flag set", d, 32'h1);
    rd(4'h4, d); chk("R6 status captured", d, 32'h0000_1234);
    wr(4'h8, 32'h5);
    rd(4'h8, d); chk("R7 nonzero write keeps flag", d, 32'h1);
    wr(4'h8, 32'h0);
    rd(4'h8, d); chk("R7 zero write clears", d, 32'h0);
    wr(4'h4, 32'hDEAD_DEAD);
    rd(4'h4, d); chk("R9 host write to status ignored", d, 32'h0000_1234);
    repeat (3) @(negedge clk);
    rd(4'h4, d); chk("R9 status held", d, 32'h0000_1234);
    ack_pulse(32'hBEEF_0002);
    rd(4'h4, d); chk("R9 status on next ack", d, 32'hBEEF_0002);
  endtask

  task automatic t_race();
    logic [31:0] d;
    wr(4'h8, 32'h0);
    rd(4'h8, d); chk("R7 pre-clear", d, 32'h0);
    host_addr = 4'h8; host_we = 1'b1; host_wdata = 32'h0;
    cop_ack = 1'b1; cop_status = 32'h0000_0099;
    @(negedge clk);
    host_we = 1'b0; cop_ack = 1'b0; cop_status = '0;
    rd(4'h8, d); chk("R8 ack wins over clear", d, 32'h1);
    rd(4'h4, d); chk("R6 status in race", d, 32'h0000_0099);
    wr(4'h8, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(4'hC, d); chk("R10 0xC empty", d, 32'h0);
    wr(4'h0, 32'h1111_2222);
    ack_pulse(32'h3333_4444);
    rd(4'hC, d); chk("R10 0xC loaded", d, 32'h0);
    rd(4'h1, d); chk("R10 0x1 loaded", d, 32'h0);
    rd(4'h9, d); chk("R10 0x9 loaded", d, 32'h0);
    rd(4'hF, d); chk("R10 0xF loaded", d, 32'h0);
    cmd_ready = 1'b1;
    @(negedge clk);
    cmd_ready = 1'b0;
    wr(4'h8, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_post_and_take();
    t_zero_post();
    t_ack();
    t_race();
    t_unmapped();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule